// File: doc/BRIEF.md
# Triggered Pattern Output Buffer

This block drives a 16-bit parallel output port that is split into four 4-bit groups. Each group has a next-data nibble, written ahead of time over a byte-wide register bus. It also has a 2-bit field that picks one of four compare-match pulse inputs from a timer. When the picked pulse is high at a clock edge and the group's enable bit is set, the group's next-data nibble moves into the port data register that drives the pins. A pattern sequencer can therefore reload the next step at leisure, and each nibble changes in step with its own timer event.

The groups form two pairs: groups 3 and 2 (port bits 15:8) and groups 1 and 0 (port bits 7:0). When both groups of a pair select the same trigger, their next data shares one byte, and the pair's second address becomes all-ones reserved space. When the two selects differ, each group has its own byte, with its data in the low nibble and a reserved upper nibble. The address map therefore follows the current trigger selections. A standby request clears the port, the trigger selects and the enables. It leaves the next-data registers as they are.

Top module: `pattern_out_buffer`

## Requirements
- R1: After reset the port output, all next-data nibbles, the trigger-select byte (address 2) and the enable byte (address 3) read 0.
- R2: At a clock edge where the group's enable bit is 1 and the trigger input picked by its select field is 1, port nibble g (bits 4g+3:4g) takes the group's next-data nibble, visible after that edge.
- R3: A group whose enable bit is 0, or whose selected trigger is 0, keeps its port nibble unchanged.
- R4: When the pair's two select fields are equal, one byte holds the pair's next data. Address 4 is {group3, group2} and address 5 is {group1, group0}, with the higher group in bits 7:4.
- R5: In that shared case, address 6 (upper pair) or address 7 (lower pair) reads 0xFF, and writes to it change nothing.
- R6: When a pair's select fields differ, group 3 is the low nibble of address 4, group 2 of address 6, group 1 of address 5 and group 0 of address 7. The upper nibble reads 0xF and ignores writes.
- R7: When a next-data write and a transfer occur in the same cycle, the port takes the old next data and the register keeps the new value.
- R8: Address 0 writes port bits 7:0 and address 1 writes port bits 15:8 directly. In a nibble where a transfer happens in the same cycle, the transfer wins.
- R9: A cycle with standby high clears the port, the selects and the enables, and keeps all next-data nibbles.
- R10: Address 2 holds the select fields with group g in bits 2g+1:2g. Address 3 holds the enable for group g in bit g, and its bits 7:4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| standby | input | 1 | Low-power request; clears the port, selects and enables |
| busAddr | input | 3 | Register byte address |
| busWr | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for busAddr |
| trig | input | 4 | Compare-match pulse inputs |
| portOut | output | 16 | Port data register driving the pins |

## Verification
The bench sweeps every group against every select value, every trigger input and both enable states, and predicts the port arithmetically. A decoder that read the wrong trigger bit or ignored the enable therefore shows up as a stray or missing nibble update. The address map is checked in shared and separate modes. A design that did not reshape the map would drop the nibble packing or fail to return 0xFF from the reserved byte. Collision cycles are checked as well: a write landing together with a trigger must give the old data to the port, and a transfer must override a direct port write. A standby that cleared next data, or missed the controls, is caught by readback.

// File: rtl/pob_pkg.sv
package pob_pkg;
  localparam int GROUPS  = 4;
  localparam int NIB     = 4;
  localparam int TRIGS   = 4;
  localparam int SEL_W   = $clog2(TRIGS);
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 8;
  localparam int PORT_W  = GROUPS * NIB;
  localparam int PAIRS   = GROUPS / 2;
  localparam int LANES   = DATA_W / NIB;

  localparam logic [ADDR_W-1:0] OFF_PORT_LO = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_PORT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_SEL     = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_OEN     = 3'd3;

  typedef struct packed {
    logic [GROUPS-1:0] ndLoad;
    logic [GROUPS-1:0] ndUseHi;
    logic [GROUPS-1:0] xfer;
    logic [PAIRS-1:0]  portByteWr;
    logic              clear;
  } strobe_t;
endpackage

// File: rtl/pob_ctrl.sv
module pob_ctrl
  import pob_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          standby,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic                          busWr,
  input  logic [DATA_W-1:0]             busWrData,
  input  logic [TRIGS-1:0]              trig,
  input  logic [GROUPS-1:0][NIB-1:0]    ndQ,
  input  logic [PORT_W-1:0]             portQ,
  output strobe_t                       str,
  output logic [DATA_W-1:0]             busRdData
);
  logic [GROUPS-1:0][SEL_W-1:0] selQ;
  logic [GROUPS-1:0]            oenQ;
  logic [PAIRS-1:0]             pairShared;
  logic [PAIRS-1:0]             wrPri, wrSec;
  logic [PAIRS-1:0][DATA_W-1:0] rdPri, rdSec;
  localparam logic [NIB-1:0]    RSV = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ <= '0;
      oenQ <= '0;
    end else if (standby) begin
      selQ <= '0;
      oenQ <= '0;
    end else if (busWr) begin
      if (busAddr == OFF_SEL) selQ <= busWrData[GROUPS*SEL_W-1:0];
      if (busAddr == OFF_OEN) oenQ <= busWrData[GROUPS-1:0];
    end
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    localparam logic [ADDR_W-1:0] PRI = ADDR_W'(5 - p);
    localparam logic [ADDR_W-1:0] SEC = ADDR_W'(7 - p);
    assign pairShared[p] = (selQ[2*p+1] == selQ[2*p]);
    assign wrPri[p] = busWr && (busAddr == PRI);
    assign wrSec[p] = busWr && (busAddr == SEC);
    assign rdPri[p] = pairShared[p] ? {ndQ[2*p+1], ndQ[2*p]} : {RSV, ndQ[2*p+1]};
    assign rdSec[p] = pairShared[p] ? {RSV, RSV} : {RSV, ndQ[2*p]};

    a_r5_reserved_ones: assert property (@(posedge clk) disable iff (!rstN)
      (pairShared[p] && busAddr == SEC) |-> busRdData == 8'hFF);
  end

  always_comb begin
    str = '0;
    str.clear = standby;
    str.portByteWr[0] = busWr && (busAddr == OFF_PORT_LO);
    str.portByteWr[1] = busWr && (busAddr == OFF_PORT_HI);
    for (int p = 0; p < PAIRS; p++) begin
      str.ndLoad[2*p+1]  = wrPri[p];
      str.ndUseHi[2*p+1] = pairShared[p];
      str.ndLoad[2*p]    = pairShared[p] ? wrPri[p] : wrSec[p];
    end
    for (int g = 0; g < GROUPS; g++) begin
      str.xfer[g] = oenQ[g] && trig[selQ[g]];
    end
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      OFF_PORT_LO: busRdData = portQ[DATA_W-1:0];
      OFF_PORT_HI: busRdData = portQ[PORT_W-1:DATA_W];
      OFF_SEL:     busRdData = selQ;
      OFF_OEN:     busRdData = {{(DATA_W-GROUPS){1'b0}}, oenQ};
      3'd4:        busRdData = rdPri[1];
      3'd5:        busRdData = rdPri[0];
      3'd6:        busRdData = rdSec[1];
      default:     busRdData = rdSec[0];
    endcase
  end

  a_r9_standby_clears: assert property (@(posedge clk) disable iff (!rstN)
    standby |=> (selQ == '0 && oenQ == '0));
endmodule

// File: rtl/pob_datapath.sv
module pob_datapath
  import pob_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    str,
  input  logic [DATA_W-1:0]          busWrData,
  output logic [GROUPS-1:0][NIB-1:0] ndQ,
  output logic [GROUPS-1:0][NIB-1:0] portQ
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam int BI   = g / LANES;
    localparam int LANE = g % LANES;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              ndQ[g] <= '0;
      else if (str.ndLoad[g]) ndQ[g] <= str.ndUseHi[g] ? busWrData[DATA_W-1 -: NIB]
                                                        : busWrData[NIB-1:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                      portQ[g] <= '0;
      else if (str.clear)             portQ[g] <= '0;
      else if (str.xfer[g])           portQ[g] <= ndQ[g];
      else if (str.portByteWr[BI])    portQ[g] <= busWrData[LANE*NIB +: NIB];
    end

    a_r2_transfer: assert property (@(posedge clk) disable iff (!rstN)
      (str.xfer[g] && !str.clear) |=> portQ[g] == $past(ndQ[g]));
    a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
      (!str.xfer[g] && !str.clear && !str.portByteWr[BI]) |=> $stable(portQ[g]));
    a_r9_nd_retained: assert property (@(posedge clk) disable iff (!rstN)
      !str.ndLoad[g] |=> $stable(ndQ[g]));
  end
endmodule

// File: rtl/pattern_out_buffer.sv
module pattern_out_buffer
  import pob_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              standby,
  input  logic [2:0]        busAddr,
  input  logic              busWr,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic [3:0]        trig,
  output logic [15:0]       portOut
);
  strobe_t                    str;
  logic [GROUPS-1:0][NIB-1:0] ndQ;
  logic [GROUPS-1:0][NIB-1:0] portQ;

  pob_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .standby(standby), .busAddr(busAddr),
    .busWr(busWr), .busWrData(busWrData), .trig(trig), .ndQ(ndQ),
    .portQ(portQ), .str(str), .busRdData(busRdData)
  );

  pob_datapath dp_i (
    .clk(clk), .rstN(rstN), .str(str), .busWrData(busWrData),
    .ndQ(ndQ), .portQ(portQ)
  );

  assign portOut = portQ;
endmodule

// File: tb/pattern_out_buffer_tb_top.sv
module pattern_out_buffer_tb_top;
  logic clk = 0, rstN = 0, standby = 0, busWr = 0;
  logic [2:0] busAddr = 0;
  logic [7:0] busWrData = 0;
  logic [7:0] busRdData;
  logic [3:0] trig = 0;
  logic [15:0] portOut;
  int checks = 0, fails = 0;
  bit done = 0;

  pattern_out_buffer dut_i (
    .clk(clk), .rstN(rstN), .standby(standby), .busAddr(busAddr), .busWr(busWr),
    .busWrData(busWrData), .busRdData(busRdData), .trig(trig), .portOut(portOut)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWrData = d; busWr = 1;
    @(negedge clk); busWr = 0;
  endtask

  task automatic rdChk(input string req, input logic [2:0] a, input logic [7:0] exp);
    busAddr = a; #1;
    check(req, {24'h0, busRdData}, {24'h0, exp});
  endtask

  task automatic pulse(input logic [3:0] t);
    @(negedge clk); trig = t;
    @(negedge clk); trig = 0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] m;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 port", portOut, 0);
    rdChk("R1 sel", 2, 8'h00);
    rdChk("R1 oen", 3, 8'h00);
    rdChk("R1 nd hi", 4, 8'h00);
    rdChk("R1 nd lo", 5, 8'h00);
    // R10 control layout
    wr(2, 8'hE4); rdChk("R10 sel", 2, 8'hE4);
    wr(3, 8'hFA); rdChk("R10 oen", 3, 8'h0A);
    // R6 separate mapping (selects 3,2,1,0 all differ)
    wr(4, 8'h37); rdChk("R6 g3", 4, 8'hF7);
    wr(6, 8'h0B); rdChk("R6 g2", 6, 8'hFB);
    wr(5, 8'hAC); rdChk("R6 g1", 5, 8'hFC);
    wr(7, 8'h0D); rdChk("R6 g0", 7, 8'hFD);
    pulse(4'hF);
    check("R2 R3 enabled groups only", portOut, 16'h70C0);
    wr(3, 8'h0F);
    pulse(4'h1);
    check("R3 unselected triggers", portOut, 16'h70CD);
    // R4 / R5 shared mapping
    wr(2, 8'h00);
    rdChk("R5 rsv hi", 6, 8'hFF);
    rdChk("R5 rsv lo", 7, 8'hFF);
    wr(4, 8'h5A); rdChk("R4 hi pair", 4, 8'h5A);
    wr(6, 8'h00); rdChk("R5 write ignored", 4, 8'h5A);
    wr(5, 8'h3C); wr(7, 8'h00); rdChk("R4 lo pair", 5, 8'h3C);
    // R7 write and trigger in same cycle
    @(negedge clk); busAddr = 4; busWrData = 8'h96; busWr = 1; trig = 4'h1;
    @(negedge clk); busWr = 0; trig = 0;
    check("R7 old data to port", portOut, 16'h5A3C);
    rdChk("R7 new data stored", 4, 8'h96);
    pulse(4'h1);
    check("R7 next transfer", portOut, 16'h963C);
    // R8 direct port write vs transfer
    wr(3, 8'h08);
    @(negedge clk); busAddr = 1; busWrData = 8'h44; busWr = 1; trig = 4'h1;
    @(negedge clk); busWr = 0; trig = 0;
    check("R8 transfer wins", portOut, 16'h943C);
    wr(0, 8'h77);
    check("R8 direct low byte", portOut, 16'h9477);
    // R9 standby
    wr(2, 8'h1B);
    @(negedge clk); standby = 1;
    @(negedge clk); standby = 0;
    check("R9 port cleared", portOut, 16'h0000);
    rdChk("R9 sel cleared", 2, 8'h00);
    rdChk("R9 oen cleared", 3, 8'h00);
    rdChk("R9 nd hi kept", 4, 8'h96);
    rdChk("R9 nd lo kept", 5, 8'h3C);
    // R2 R3 sweep: group x select x trigger x enable
    m = 16'h0000;
    for (int g = 0; g < 4; g++)
      for (int s = 0; s < 4; s++)
        for (int t = 0; t < 4; t++)
          for (int e = 0; e < 2; e++) begin
            int idx;
            logic [15:0] pat;
            logic [1:0] sv;
            idx = ((g * 4 + s) * 4 + t) * 2 + e;
            pat = 16'(idx * 16'h1357 + 16'h0F1E);
            sv = 2'(s);
            wr(2, {sv, sv, sv, sv});
            wr(3, e != 0 ? 8'(1 << g) : 8'h00);
            wr(4, pat[15:8]);
            wr(5, pat[7:0]);
            pulse(4'(1 << t));
            if (e != 0 && s == t) m[g*4 +: 4] = pat[g*4 +: 4];
            check("R2 R3 sweep", portOut, m);
          end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule